// File: doc/BRIEF.md
# Request packet framer for a narrow serial link

The block turns one request (command code, read or write, a 40-bit or 64-bit address, a byte count and up to a few words of write data) into a packet of 32-bit words. It then shifts that packet out over a point-to-point link whose width is fixed at build time. A request is offered on a valid/ready handshake. The framer captures the whole packet at acceptance and then drives the link with one slice per clock. It holds its ready output low until the packet is on the wire.

A packet begins with a control word. The command code, the read/write flag, the byte-significance field, the data word count and the low address byte share that control word. The next word carries address bits 39 down to 8. When 64-bit addressing is requested, an extension word goes in front of the control word. The extension word carries a reserved command code and address bits 63 down to 40. A write appends its data words after the address word. Bytes past the requested length are zeroed. A read carries no data.

Top module: `link_req_framer`

## Requirements
- R1: The packet is, in order: the extension word (64-bit mode only), the control word, the address word, then for a write ceil(bytes/4) data words. The total is 2 + (1 if 64-bit) + (data words if write).
- R2: Control word fields: [5:0] command code; [6] 1 for write and 0 for read; [7] zero; [9:8] the low two bits of byte-count-minus-one (the number of significant bytes in the last data word, minus one); [15:10] data word count minus one, which is (byte-count-minus-one)>>2; [23:16] zero; [31:24] address bits [7:0].
- R3: The word after the control word is address bits [39:8].
- R4: In 64-bit mode the first word is [5:0]=6'h3F, [7:6]=0, [31:8]=address [63:40]. In 40-bit mode address bits [63:40] affect no word.
- R5: Data word j of a write is write data bits [32j+31:32j], with every byte whose index j*4+b exceeds byte-count-minus-one driven to zero.
- R6: Each word is sent least-significant slice first over 32/LINK_W consecutive cycles. link_valid stays high with no gap from the first slice to the last slice of a packet.
- R7: link_sop is high only with link_valid, on the first slice of each packet, and exactly once per packet.
- R8: req_ready is high when idle. It falls the cycle after a request is accepted and stays low until the last slice is on the link. A request offered while req_ready is low is ignored.
- R9: Synchronous active-high reset abandons any packet in progress. After reset link_valid and link_sop are low, link_data is zero and req_ready is high. While link_valid is low, link_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Framer can accept a request |
| req_cmd | input | 6 | Command code |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr64 | input | 1 | 1 selects 64-bit addressing |
| req_addr | input | 64 | Request address |
| req_len_m1 | input | LEN_W | Byte count minus one |
| req_wdata | input | MAX_WORDS*32 | Write data, byte 0 in the low bits |
| link_valid | output | 1 | A slice is on the link |
| link_sop | output | 1 | First slice of a packet |
| link_data | output | LINK_W | Link slice |

## Verification
The hardest cases to reach from the ports are a request offered while a packet is in flight and a reset that lands partway through a word. The bench runs the framer at all five link widths side by side from one shared request bus. It pulses a second request in the cycle right after acceptance, when every instance is busy. It raises reset while the narrowest instance is still inside a long write. Every slice stream is rebuilt into words and compared against a model of the packet layout, so a misplaced address bit, a wrong significance field or a stray data byte shows up at each width.

// File: rtl/link_req_framer_pkg.sv
package link_req_framer_pkg;

  localparam int WORD_W = 32;
  localparam logic [5:0] EXT_CMD = 6'h3F;

  typedef struct packed {
    logic [5:0]  cmd;
    logic        wr;
    logic        a64;
    logic [63:0] addr;
  } req_hdr_t;

  function automatic logic [WORD_W-1:0] make_ctrl(
    input logic [5:0] cmd,
    input logic       wr,
    input logic [1:0] sig_m1,
    input logic [5:0] wcnt_m1,
    input logic [7:0] addr_lo
  );
    return {addr_lo, 8'h00, wcnt_m1, sig_m1, 1'b0, wr, cmd};
  endfunction

  function automatic logic [WORD_W-1:0] make_ext(input logic [23:0] addr_hi);
    return {addr_hi, 2'b00, EXT_CMD};
  endfunction

endpackage

// File: rtl/framer_build.sv
module framer_build
  import link_req_framer_pkg::*;
#(
  parameter int MAX_WORDS = 4,
  parameter int LEN_W     = $clog2(MAX_WORDS * 4),
  parameter int NPKT      = MAX_WORDS + 3,
  parameter int IDX_W     = $clog2(NPKT)
) (
  input  req_hdr_t                    hdr,
  input  logic [LEN_W-1:0]            len_m1,
  input  logic [MAX_WORDS*WORD_W-1:0] wdata,
  output logic [WORD_W-1:0]           pkt [NPKT],
  output logic [IDX_W-1:0]            last_idx
);

  localparam int MAX_BYTES = MAX_WORDS * 4;

  logic [MAX_WORDS*WORD_W-1:0] wmasked;
  logic [WORD_W-1:0]           ctrl_w;
  logic [WORD_W-1:0]           ext_w;
  logic [WORD_W-1:0]           addr_w;
  logic [LEN_W-1:0]            wcnt_m1;

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_mask
    assign wmasked[b*8 +: 8] = (LEN_W'(b) <= len_m1) ? wdata[b*8 +: 8] : 8'h00;
  end

  assign wcnt_m1 = len_m1 >> 2;
  assign ctrl_w  = make_ctrl(hdr.cmd, hdr.wr, len_m1[1:0], 6'(wcnt_m1), hdr.addr[7:0]);
  assign ext_w   = make_ext(hdr.addr[63:40]);
  assign addr_w  = hdr.addr[39:8];

  always_comb begin
    for (int k = 0; k < NPKT; k++) pkt[k] = '0;
    if (hdr.a64) begin
      pkt[0] = ext_w;
      pkt[1] = ctrl_w;
      pkt[2] = addr_w;
      for (int j = 0; j < MAX_WORDS; j++) pkt[3+j] = wmasked[j*WORD_W +: WORD_W];
    end else begin
      pkt[0] = ctrl_w;
      pkt[1] = addr_w;
      for (int j = 0; j < MAX_WORDS; j++) pkt[2+j] = wmasked[j*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    last_idx = IDX_W'(1) + IDX_W'(hdr.a64);
    if (hdr.wr) last_idx = last_idx + IDX_W'(wcnt_m1) + IDX_W'(1);
  end

endmodule

// File: rtl/framer_serial.sv
module framer_serial
  import link_req_framer_pkg::*;
#(
  parameter int LINK_W = 8,
  parameter int NPKT   = 7,
  parameter int IDX_W  = $clog2(NPKT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] pkt [NPKT],
  input  logic [IDX_W-1:0]  last_idx,
  output logic              busy,
  output logic              link_valid,
  output logic              link_sop,
  output logic [LINK_W-1:0] link_data
);

  localparam int SLICES = WORD_W / LINK_W;
  localparam int SIDX_W = (SLICES > 1) ? $clog2(SLICES) : 1;

  logic [WORD_W-1:0] words_q [NPKT];
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  widx;
  logic [SIDX_W-1:0] sidx;
  logic [WORD_W-1:0] cur_word;
  logic [LINK_W-1:0] cur_slice;
  logic              word_end;

  assign cur_word  = words_q[widx];
  assign cur_slice = LINK_W'(cur_word >> (int'(sidx) * LINK_W));
  assign word_end  = (sidx == SIDX_W'(SLICES - 1));

  always_ff @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < NPKT; k++) words_q[k] <= pkt[k];
      last_q <= last_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      widx       <= '0;
      sidx       <= '0;
      link_valid <= 1'b0;
      link_sop   <= 1'b0;
      link_data  <= '0;
    end else if (load) begin
      busy       <= 1'b1;
      widx       <= '0;
      sidx       <= '0;
      link_valid <= 1'b0;
      link_sop   <= 1'b0;
      link_data  <= '0;
    end else if (busy) begin
      link_valid <= 1'b1;
      link_sop   <= (widx == '0) && (sidx == '0);
      link_data  <= cur_slice;
      if (word_end) begin
        sidx <= '0;
        if (widx == last_q) busy <= 1'b0;
        else                widx <= widx + IDX_W'(1);
      end else begin
        sidx <= sidx + SIDX_W'(1);
      end
    end else begin
      link_valid <= 1'b0;
      link_sop   <= 1'b0;
      link_data  <= '0;
    end
  end

endmodule

// File: rtl/link_req_framer.sv
module link_req_framer
  import link_req_framer_pkg::*;
#(
  parameter int LINK_W    = 8,
  parameter int MAX_WORDS = 4,
  parameter int LEN_W     = $clog2(MAX_WORDS * 4)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [5:0]                  req_cmd,
  input  logic                        req_write,
  input  logic                        req_addr64,
  input  logic [63:0]                 req_addr,
  input  logic [LEN_W-1:0]            req_len_m1,
  input  logic [MAX_WORDS*WORD_W-1:0] req_wdata,
  output logic                        link_valid,
  output logic                        link_sop,
  output logic [LINK_W-1:0]           link_data
);

  localparam int NPKT  = MAX_WORDS + 3;
  localparam int IDX_W = $clog2(NPKT);

  req_hdr_t          hdr;
  logic [WORD_W-1:0] pkt [NPKT];
  logic [IDX_W-1:0]  last_idx;
  logic              busy;
  logic              load;

  assign hdr       = '{cmd: req_cmd, wr: req_write, a64: req_addr64, addr: req_addr};
  assign req_ready = !busy;
  assign load      = req_valid && !busy;

  framer_build #(
    .MAX_WORDS (MAX_WORDS),
    .LEN_W     (LEN_W),
    .NPKT      (NPKT),
    .IDX_W     (IDX_W)
  ) u_build (
    .hdr      (hdr),
    .len_m1   (req_len_m1),
    .wdata    (req_wdata),
    .pkt      (pkt),
    .last_idx (last_idx)
  );

  framer_serial #(
    .LINK_W (LINK_W),
    .NPKT   (NPKT),
    .IDX_W  (IDX_W)
  ) u_serial (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .pkt        (pkt),
    .last_idx   (last_idx),
    .busy       (busy),
    .link_valid (link_valid),
    .link_sop   (link_sop),
    .link_data  (link_data)
  );

endmodule

// File: rtl/link_req_framer_chk.sv
module link_req_framer_chk #(
  parameter int LINK_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              link_valid,
  input logic              link_sop,
  input logic [LINK_W-1:0] link_data
);

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R8

  AST_SOP_ON_START: assert property (@(posedge clk) disable iff (rst)
    $rose(link_valid) |-> link_sop); // R7

  AST_SOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    link_sop |=> !link_sop); // R7

  AST_SOP_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    link_sop |-> link_valid); // R7

  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (link_valid && !req_ready) |=> link_valid); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !link_valid |-> (link_data == '0)); // R9

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!link_valid && req_ready)); // R9

endmodule

bind link_req_framer link_req_framer_chk #(.LINK_W(LINK_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .link_valid (link_valid),
  .link_sop   (link_sop),
  .link_data  (link_data)
);

// File: tb/link_req_framer_test.sv
`timescale 1ns/1ps
module link_req_framer_test;

  localparam int NW    = 5;
  localparam int MAXPW = 8;

  typedef struct packed {
    logic        wr;
    logic        a64;
    logic [5:0]  cmd;
    logic [3:0]  len;
    logic [63:0] addr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 6'h05, 4'd0,  64'hFFFF_FF12_3456_789A},
    '{1'b1, 1'b0, 6'h0A, 4'd0,  64'h0000_0011_2233_4455},
    '{1'b1, 1'b0, 6'h21, 4'd6,  64'h0000_00AB_CDEF_0123},
    '{1'b1, 1'b1, 6'h12, 4'd15, 64'hDEAD_BEEF_CAFE_F00D},
    '{1'b0, 1'b1, 6'h07, 4'd3,  64'h0000_0100_0000_00FF},
    '{1'b1, 1'b1, 6'h30, 4'd4,  64'h8001_2345_6789_ABCD},
    '{1'b0, 1'b0, 6'h3F, 4'd11, 64'h5A5A_5A00_0000_0001},
    '{1'b1, 1'b0, 6'h01, 4'd12, 64'h0000_0080_4020_1008}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [5:0]   req_cmd = '0;
  logic         req_write = 1'b0;
  logic         req_addr64 = 1'b0;
  logic [63:0]  req_addr = '0;
  logic [3:0]   req_len_m1 = '0;
  logic [127:0] req_wdata = '0;

  logic        rdy [NW];
  logic        lv  [NW];
  logic        ls  [NW];
  logic [31:0] ld  [NW];

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NW; g++) begin : gw
    logic [(2<<g)-1:0] ldn;
    link_req_framer #(.LINK_W(2 << g)) uut (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid),
      .req_ready  (rdy[g]),
      .req_cmd    (req_cmd),
      .req_write  (req_write),
      .req_addr64 (req_addr64),
      .req_addr   (req_addr),
      .req_len_m1 (req_len_m1),
      .req_wdata  (req_wdata),
      .link_valid (lv[g]),
      .link_sop   (ls[g]),
      .link_data  (ldn)
    );
    assign ld[g] = 32'(ldn);
  end

  function automatic int wof(int g);
    return 2 << g;
  endfunction

  // slice stream decoder, one per width
  logic [31:0] cap [NW][MAXPW];
  logic [31:0] acc [NW];
  int nw [NW];
  int sl [NW];
  int sops [NW];
  int slices [NW];

  initial begin
    for (int g = 0; g < NW; g++) begin
      acc[g] = '0; nw[g] = 0; sl[g] = 0; sops[g] = 0; slices[g] = 0;
    end
  end

  always @(negedge clk) begin
    for (int g = 0; g < NW; g++) begin
      if (lv[g]) begin
        if (ls[g]) begin
          nw[g] = 0; sl[g] = 0; acc[g] = '0; sops[g] = sops[g] + 1;
        end
        acc[g] = acc[g] | (ld[g] << (sl[g] * wof(g)));
        sl[g] = sl[g] + 1;
        slices[g] = slices[g] + 1;
        if (sl[g] == 32 / wof(g)) begin
          if (nw[g] < MAXPW) cap[g][nw[g]] = acc[g];
          nw[g] = nw[g] + 1;
          sl[g] = 0;
          acc[g] = '0;
        end
      end
    end
  end

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mkdata(int i);
    logic [127:0] d;
    for (int b = 0; b < 16; b++) d[b*8 +: 8] = 8'h80 | 8'(i * 16 + b);
    return d;
  endfunction

  function automatic int exp_count(vec_t v);
    return 2 + int'(v.a64) + (v.wr ? (int'(v.len) >> 2) + 1 : 0);
  endfunction

  function automatic logic [31:0] exp_word(vec_t v, logic [127:0] wd, int k);
    int kk;
    int j;
    logic [31:0] w;
    if (v.a64 && k == 0) return {v.addr[63:40], 2'b00, 6'h3F};
    kk = k - int'(v.a64);
    if (kk == 0) return {v.addr[7:0], 8'h00, 6'(v.len >> 2), v.len[1:0], 1'b0, v.wr, v.cmd};
    if (kk == 1) return v.addr[39:8];
    j = kk - 2;
    for (int b = 0; b < 4; b++)
      w[b*8 +: 8] = ((j * 4 + b) <= int'(v.len)) ? wd[(j*4+b)*8 +: 8] : 8'h00;
    return w;
  endfunction

  function automatic string word_req(vec_t v, int k);
    int kk;
    if (v.a64 && k == 0) return "R4";
    kk = k - int'(v.a64);
    if (kk == 0) return "R2";
    if (kk == 1) return "R3";
    return "R5";
  endfunction

  function automatic bit all_ready();
    for (int g = 0; g < NW; g++) if (!rdy[g]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit all_idle();
    for (int g = 0; g < NW; g++) if (!rdy[g] || lv[g]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drive(vec_t v, logic [127:0] wd);
    req_cmd    = v.cmd;
    req_write  = v.wr;
    req_addr64 = v.a64;
    req_addr   = v.addr;
    req_len_m1 = v.len;
    req_wdata  = wd;
  endtask

  task automatic send(vec_t v, logic [127:0] wd);
    while (!all_ready()) @(negedge clk);
    drive(v, wd);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!all_idle()) @(negedge clk);
  endtask

  task automatic check_pkt(vec_t v, logic [127:0] wd, int sop0 [NW], int sl0 [NW]);
    int n;
    n = exp_count(v);
    for (int g = 0; g < NW; g++) begin
      chk(nw[g] == n, "R1", $sformatf("word count w%0d", wof(g)), 64'(nw[g]), 64'(n));
      for (int k = 0; k < n && k < MAXPW; k++)
        chk(cap[g][k] == exp_word(v, wd, k), word_req(v, k),
            $sformatf("R6 word %0d w%0d", k, wof(g)), 64'(cap[g][k]), 64'(exp_word(v, wd, k)));
      chk(sops[g] - sop0[g] == 1, "R7", $sformatf("sop count w%0d", wof(g)),
          64'(sops[g] - sop0[g]), 64'd1);
      chk(slices[g] - sl0[g] == n * (32 / wof(g)), "R6", $sformatf("slice count w%0d", wof(g)),
          64'(slices[g] - sl0[g]), 64'(n * (32 / wof(g))));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int sop0 [NW];
    int sl0 [NW];
    vec_t v2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    for (int g = 0; g < NW; g++) begin
      chk(rdy[g] == 1'b1, "R9", "ready after reset", 64'(rdy[g]), 64'd1);
      chk(lv[g] == 1'b0 && ls[g] == 1'b0, "R9", "link idle after reset", 64'({lv[g], ls[g]}), 64'd0);
      chk(ld[g] == '0, "R9", "link data zero after reset", 64'(ld[g]), 64'd0);
    end

    // vector table
    for (int i = 0; i < NV; i++) begin
      for (int g = 0; g < NW; g++) begin sop0[g] = sops[g]; sl0[g] = slices[g]; end
      send(VECS[i], mkdata(i));
      if (i == 0)
        for (int g = 0; g < NW; g++)
          chk(rdy[g] == 1'b0, "R8", "ready low after accept", 64'(rdy[g]), 64'd0);
      wait_done();
      check_pkt(VECS[i], mkdata(i), sop0, sl0);
    end

    // R8 request during busy is ignored
    v2 = '{1'b0, 1'b1, 6'h2C, 4'd2, 64'h1111_2222_3333_4444};
    for (int g = 0; g < NW; g++) begin sop0[g] = sops[g]; sl0[g] = slices[g]; end
    send(VECS[3], mkdata(9));
    drive(v2, mkdata(10));
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    for (int g = 0; g < NW; g++)
      chk(sops[g] - sop0[g] == 1, "R8", $sformatf("busy request ignored w%0d", wof(g)),
          64'(sops[g] - sop0[g]), 64'd1);
    check_pkt(VECS[3], mkdata(9), sop0, sl0);

    // R9 reset in the middle of a packet
    send(VECS[7], mkdata(11));
    repeat (5) @(negedge clk);
    chk(lv[0] == 1'b1, "R9", "narrow link busy before reset", 64'(lv[0]), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    for (int g = 0; g < NW; g++) begin
      chk(lv[g] == 1'b0 && ld[g] == '0, "R9", $sformatf("mid-packet reset idles w%0d", wof(g)),
          64'({lv[g], ld[g]}), 64'd0);
      chk(rdy[g] == 1'b1, "R9", $sformatf("ready after mid reset w%0d", wof(g)), 64'(rdy[g]), 64'd1);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int g = 0; g < NW; g++) begin sop0[g] = sops[g]; sl0[g] = slices[g]; end
    send(VECS[5], mkdata(12));
    wait_done();
    check_pkt(VECS[5], mkdata(12), sop0, sl0);

    finish_run();
  end

endmodule